// File: doc/BRIEF.md
# Narrow External Bus Access Sequencer

This block takes one internal memory request of byte, half-word or word size and carries it out as a series of byte-wide beats on an external bus. The bus has separate address lines, an 8-bit data path with an output enable, a read strobe, a write-enable strobe and a data-acknowledge input. Bytes are sent least significant first. The address low bits step through the lanes of the access. On reads, each returned byte is stored in its lane of a 32-bit result.

Each beat has a programmable address-setup count and a programmable data-wait count. With the handshake on, the acknowledge is looked at only after both counts have run out. The beat then ends exactly two cycles after the acknowledge is taken. A new beat does not start while the acknowledge is still high. Some settings are illegal: handshake without synchronous operation, handshake on the second region with a clock ratio other than 4:1, and an unused size code. A request with any of these is refused with a one-cycle error pulse and no bus activity.

Top module: `narrow_bus_seq`

## Requirements
- R1: A byte request (size code 00) issues exactly one beat, at the request address. Its data uses lane 0: write data bits [7:0] on writes, result bits [7:0] on reads.
- R2: A half-word request (size code 01) issues two beats. The first has address bit 0 cleared and carries bits [7:0]. The second has address bit 0 set and carries bits [15:8]. All higher address bits come from the request.
- R3: A word request (size code 10) issues four beats with address bits [1:0] of 00, 01, 10, 11 in that order. Beat i carries bits [8i+7:8i].
- R4: During a write beat, ext_we and ext_doe are high and ext_dout holds that beat's byte. During a read beat, ext_rd is high and ext_doe is low. Both strobes are never high together.
- R5: On reads, the byte on ext_din at the last cycle of beat i goes to lane i of rd_data. Lanes with no beat read zero, because rd_data is cleared when a legal request is accepted. req_done is high for exactly one cycle, the cycle after the last beat.
- R6: With the handshake on, a beat holds its strobe for at least setup+wait+1 cycles. An acknowledge that arrives earlier has no effect until then.
- R7: With the handshake on, the beat ends exactly two cycles after the acknowledge is taken. If the acknowledge is raised in strobe cycle c, the strobe lasts max(c, setup+wait+1)+2 cycles.
- R8: Between beats, and before the first beat when the handshake is on, no beat starts while ext_ack is high. The next beat starts in the cycle after ext_ack is seen low, and there is at least one idle cycle between beats.
- R9: With the handshake off, each beat lasts exactly setup+wait+1 cycles and ext_ack has no effect.
- R10: A request is refused if any of these holds: the handshake is on while cfg_sync is low; the handshake is on for the second region (cfg_region3=1) with cfg_ratio other than 10 (the 4:1 code); or the size code is 11. A refused request gives req_err high for one cycle and never raises a strobe.
- R11: After reset, strobes, output enable, req_done, req_err and rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 illegal |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8*LANES | Write data, lane 0 sent first |
| cfg_region3 | input | 1 | Request targets the second configurable region |
| cfg_hs_en | input | 1 | Acknowledge handshake on |
| cfg_sync | input | 1 | Synchronous operation selected |
| cfg_ratio | input | 2 | Clock ratio code, 10 means 4:1 |
| cfg_setup | input | CW | Address-setup cycles |
| cfg_wait | input | CW | Data-wait cycles |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle refusal pulse |
| rd_data | output | 8*LANES | Merged read result |
| ext_addr | output | AW | External address |
| ext_dout | output | 8 | External write byte |
| ext_doe | output | 1 | Data output enable |
| ext_rd | output | 1 | Read strobe |
| ext_we | output | 1 | Write-enable strobe |
| ext_din | input | 8 | External read byte |
| ext_ack | input | 1 | Data acknowledge |

## Verification
Two events can land on the same clock edge: the end of a beat, and the bus deciding whether the next beat may start while the acknowledge is still held. The bench keeps the acknowledge high for 0, 1 or 2 cycles after a strobe falls. It then counts the idle cycles before the next strobe and compares the count with the hold time plus one. It also raises the acknowledge both before and after the setup+wait window opens. The strobe length must then equal the later of the two points plus the two-cycle tail.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
   typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
   typedef enum logic [2:0] {ST_IDLE, ST_BEAT, ST_GAP, ST_DONE, ST_ERR} seq_st_e;
   localparam logic [1:0] RATIO_4TO1 = 2'd2;

   function automatic logic cfg_illegal(input logic hs, input logic sync, input logic region3,
                                        input logic [1:0] ratio, input logic [1:0] size);
      return (hs && !sync) || (hs && region3 && ratio != RATIO_4TO1) || (size == SZ_BAD);
   endfunction
endpackage

// File: rtl/nbs_beat_timer.sv
module nbs_beat_timer #(
   parameter int CW   = 4,
   parameter int TAIL = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [CW:0] load_cnt,
   input  logic        hs_en,
   input  logic        ack,
   output logic        beat_end
);
   localparam int TW = (TAIL > 1) ? $clog2(TAIL) : 1;

   logic          busy_q, tail_q, win_open;
   logic [CW:0]   cnt_q;
   logic [TW-1:0] tcnt_q;

   assign win_open = busy_q && !tail_q && (cnt_q == '0);
   assign beat_end = busy_q && (tail_q ? (tcnt_q == '0) : (win_open && !hs_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tail_q <= 1'b0;
         cnt_q  <= '0;
         tcnt_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         tail_q <= 1'b0;
         cnt_q  <= load_cnt;
      end else if (busy_q) begin
         if (tail_q) begin
            if (tcnt_q == '0) begin
               busy_q <= 1'b0;
               tail_q <= 1'b0;
            end else begin
               tcnt_q <= tcnt_q - 1'b1;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (!hs_en) begin
            busy_q <= 1'b0;
         end else if (ack) begin
            tail_q <= 1'b1;
            tcnt_q <= TW'(TAIL - 1);
         end
      end
   end
endmodule

// File: rtl/nbs_lane_merge.sv
module nbs_lane_merge #(
   parameter int LANES = 4,
   localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               capture,
   input  logic [IW-1:0]      lane,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dout[8*g +: 8] <= '0;
         else if (clear)
            dout[8*g +: 8] <= '0;
         else if (capture && lane == IW'(g))
            dout[8*g +: 8] <= din;
      end
   end
endmodule

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq
   import nbs_pkg::*;
#(
   parameter int AW    = 16,
   parameter int LANES = 4,
   parameter int CW    = 4,
   parameter int TAIL  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   input  logic [1:0]         req_size,
   input  logic               req_write,
   input  logic [8*LANES-1:0] req_wdata,
   input  logic               cfg_region3,
   input  logic               cfg_hs_en,
   input  logic               cfg_sync,
   input  logic [1:0]         cfg_ratio,
   input  logic [CW-1:0]      cfg_setup,
   input  logic [CW-1:0]      cfg_wait,
   output logic               req_done,
   output logic               req_err,
   output logic [8*LANES-1:0] rd_data,
   output logic [AW-1:0]      ext_addr,
   output logic [7:0]         ext_dout,
   output logic               ext_doe,
   output logic               ext_rd,
   output logic               ext_we,
   input  logic [7:0]         ext_din,
   input  logic               ext_ack
);
   localparam int DW = 8 * LANES;
   localparam int IW = $clog2(LANES);

   if (LANES != 4) begin : g_bad_lanes
      $error("narrow_bus_seq: LANES must be 4");
   end
   if (AW < 2) begin : g_bad_aw
      $error("narrow_bus_seq: AW must be at least 2");
   end
   if (TAIL < 1) begin : g_bad_tail
      $error("narrow_bus_seq: TAIL must be at least 1");
   end

   seq_st_e       st_q;
   logic [AW-1:0] base_q;
   size_e         size_q;
   logic [IW-1:0] idx_q, last_q;
   logic          wr_q, hs_q;
   logic [DW-1:0] wdata_q;
   logic [CW:0]   span_q, span_in;
   logic          accept, bad, go_first, start, beat_end, on_beat;

   assign accept   = (st_q == ST_IDLE) && req_valid && !(cfg_hs_en && ext_ack);
   assign bad      = cfg_illegal(cfg_hs_en, cfg_sync, cfg_region3, cfg_ratio, req_size);
   assign go_first = accept && !bad;
   assign start    = go_first || ((st_q == ST_GAP) && !(hs_q && ext_ack));
   assign span_in  = {1'b0, cfg_setup} + {1'b0, cfg_wait};

   nbs_beat_timer #(.CW(CW), .TAIL(TAIL)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .load_cnt (go_first ? span_in : span_q),
      .hs_en    (hs_q),
      .ack      (ext_ack),
      .beat_end (beat_end)
   );

   nbs_lane_merge #(.LANES(LANES)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (go_first),
      .capture (beat_end && !wr_q),
      .lane    (idx_q),
      .din     (ext_din),
      .dout    (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         base_q  <= '0;
         size_q  <= SZ_BYTE;
         idx_q   <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
         hs_q    <= 1'b0;
         wdata_q <= '0;
         span_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               if (bad) begin
                  st_q <= ST_ERR;
               end else begin
                  st_q    <= ST_BEAT;
                  base_q  <= req_addr;
                  size_q  <= size_e'(req_size);
                  idx_q   <= '0;
                  wr_q    <= req_write;
                  hs_q    <= cfg_hs_en;
                  wdata_q <= req_wdata;
                  span_q  <= span_in;
                  unique case (size_e'(req_size))
                     SZ_HALF: last_q <= IW'(1);
                     SZ_WORD: last_q <= IW'(LANES - 1);
                     default: last_q <= '0;
                  endcase
               end
            end
            ST_BEAT: if (beat_end) begin
               if (idx_q == last_q) begin
                  st_q <= ST_DONE;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_GAP;
               end
            end
            ST_GAP:  if (start) st_q <= ST_BEAT;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (size_q)
         SZ_HALF: ext_addr = {base_q[AW-1:1], idx_q[0]};
         SZ_WORD: ext_addr = {base_q[AW-1:2], idx_q};
         default: ext_addr = base_q;
      endcase
   end

   assign on_beat  = (st_q == ST_BEAT);
   assign ext_rd   = on_beat && !wr_q;
   assign ext_we   = on_beat && wr_q;
   assign ext_doe  = ext_we;
   assign ext_dout = ext_we ? wdata_q[8*idx_q +: 8] : 8'h00;
   assign req_done = (st_q == ST_DONE);
   assign req_err  = (st_q == ST_ERR);
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
   input logic clk,
   input logic rst_n,
   input logic ext_rd,
   input logic ext_we,
   input logic ext_doe,
   input logic ext_ack,
   input logic req_done,
   input logic req_err,
   input logic hs_q
);
   logic strobe;
   assign strobe = ext_rd || ext_we;

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && ext_we));
   assert_doe_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_doe |-> ext_we);
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);
   assert_done_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_done) |-> $past(strobe));
   assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> !strobe);
   assert_tail_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(strobe) && hs_q) |-> $past(ext_ack, 3));
   assert_no_start_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(strobe) && hs_q) |-> !$past(ext_ack));
endmodule

bind narrow_bus_seq nbs_checker u_nbs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ext_rd   (ext_rd),
   .ext_we   (ext_we),
   .ext_doe  (ext_doe),
   .ext_ack  (ext_ack),
   .req_done (req_done),
   .req_err  (req_err),
   .hs_q     (hs_q)
);

// File: tb/narrow_bus_seq_test.sv
module narrow_bus_seq_test;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_size = '0, cfg_ratio = '0;
   logic [31:0] req_wdata = '0;
   logic        cfg_region3 = 0, cfg_hs_en = 0, cfg_sync = 1, ext_ack = 0;
   logic [3:0]  cfg_setup = '0, cfg_wait = '0;
   logic        req_done, req_err, ext_doe, ext_rd, ext_we;
   logic [31:0] rd_data;
   logic [15:0] ext_addr;
   logic [7:0]  ext_dout, ext_din;
   int          checks = 0, failures = 0;

   always #10 clk = ~clk;
   assign ext_din = ext_addr[7:0] ^ 8'hA5;

   narrow_bus_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .cfg_region3(cfg_region3), .cfg_hs_en(cfg_hs_en), .cfg_sync(cfg_sync),
      .cfg_ratio(cfg_ratio), .cfg_setup(cfg_setup), .cfg_wait(cfg_wait),
      .req_done(req_done), .req_err(req_err), .rd_data(rd_data),
      .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
      .ext_rd(ext_rd), .ext_we(ext_we), .ext_din(ext_din), .ext_ack(ext_ack)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reset_check();
      check({ext_rd, ext_we, ext_doe, req_done, req_err} == 5'b0, "R11", "controls after reset",
            {ext_rd, ext_we, ext_doe, req_done, req_err}, 0);
      check(rd_data == 32'h0, "R11", "rd_data after reset", rd_data, 0);
   endtask

   // c: strobe cycle in which ack rises; h: cycles ack is held after a strobe falls
   task automatic run_access(input string tag, input logic [1:0] sz, input logic [15:0] addr,
                             input logic wr, input logic [31:0] wd, input logic [3:0] su,
                             input logic [3:0] wt, input logic hs, input logic reg3,
                             input logic [1:0] ratio, input int c, input int h, input logic force_ack);
      int nb, len, hc, lc, beat, exp_len;
      logic [15:0] ea;
      logic [31:0] exp_rd;
      nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      len = int'(su) + int'(wt);
      hc = 0; lc = 0; beat = 0; exp_rd = '0; ea = '0;
      @(negedge clk);
      cfg_hs_en = hs; cfg_sync = 1'b1; cfg_region3 = reg3; cfg_ratio = ratio;
      cfg_setup = su; cfg_wait = wt;
      req_size = sz; req_addr = addr; req_write = wr; req_wdata = wd; req_valid = 1'b1;
      ext_ack = (!hs && force_ack);
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 3000; t++) begin
         if (ext_rd || ext_we) begin
            if (hc == 0) begin
               if (beat > 0)
                  check(lc == h + 1, "R8", {tag, " idle cycles between beats"}, lc, h + 1);
               ea = (sz == 2'd0) ? addr : (sz == 2'd1) ? {addr[15:1], beat[0]} : {addr[15:2], beat[1:0]};
               check(ext_addr == ea, (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3",
                     {tag, " beat address"}, ext_addr, ea);
               if (wr)
                  check(ext_we && ext_doe && !ext_rd && ext_dout == wd[8*beat +: 8], "R4",
                        {tag, " write beat byte"}, {ext_we, ext_doe, ext_dout}, {2'b11, wd[8*beat +: 8]});
               else begin
                  check(ext_rd && !ext_doe && !ext_we, "R4", {tag, " read beat controls"},
                        {ext_rd, ext_doe, ext_we}, 3'b100);
                  exp_rd[8*beat +: 8] = ea[7:0] ^ 8'hA5;
               end
            end
            hc++;
            if (hs && hc >= c) ext_ack = 1'b1;
         end else begin
            if (hc > 0) begin
               exp_len = hs ? (((c > len + 1) ? c : len + 1) + 2) : len + 1;
               check(hc == exp_len, hs ? "R7" : "R9", {tag, " strobe length"}, hc, exp_len);
               beat++; hc = 0; lc = 0;
               if (beat == nb) begin
                  check(req_done == 1'b1, "R5", {tag, " done after last beat"}, req_done, 1);
                  @(negedge clk);
                  check(req_done == 1'b0 && !ext_rd && !ext_we, "R5", {tag, " done one cycle"},
                        {req_done, ext_rd, ext_we}, 0);
                  break;
               end
            end else if (beat == 0 && t > 40) begin
               check(1'b0, "R1", {tag, " no beat started"}, 0, 1);
               break;
            end
            lc++;
            if (hs && lc > h) ext_ack = 1'b0;
         end
         @(negedge clk);
      end
      check(beat == nb, tag, "beat count", beat, nb);
      check(rd_data == exp_rd, "R5", {tag, " merged read data"}, rd_data, exp_rd);
      ext_ack = 1'b0;
   endtask

   task automatic run_error(input string tag, input logic [1:0] sz, input logic hs,
                            input logic sync, input logic reg3, input logic [1:0] ratio);
      @(negedge clk);
      cfg_hs_en = hs; cfg_sync = sync; cfg_region3 = reg3; cfg_ratio = ratio;
      cfg_setup = 4'd1; cfg_wait = 4'd1; req_size = sz; req_write = 1'b0; ext_ack = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_err == 1'b1 && !ext_rd && !ext_we, "R10", {tag, " refusal pulse"},
            {req_err, ext_rd, ext_we}, 3'b100);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!req_err && !ext_rd && !ext_we && !req_done, "R10", {tag, " stays quiet"},
               {req_err, ext_rd, ext_we, req_done}, 0);
      end
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      reset_check();
      rst_n = 1'b1;
      @(negedge clk);
      reset_check();
      // R1 R6 R7: byte read, early ack held until window opens
      run_access("byte_rd_hs", 2'd0, 16'h1233, 1'b0, 32'h0, 4'd1, 4'd1, 1'b1, 1'b0, 2'd0, 1, 0, 1'b0);
      // R2 R4 R8: half write, late ack, ack held two idle cycles
      run_access("half_wr_hs", 2'd1, 16'h4440, 1'b1, 32'h0000_BEEF, 4'd2, 4'd0, 1'b1, 1'b0, 2'd1, 6, 2, 1'b0);
      // R3 R5: word read with zero setup and wait, region 3 at 4:1
      run_access("word_rd_hs", 2'd2, 16'h7ABD, 1'b0, 32'h0, 4'd0, 4'd0, 1'b1, 1'b1, 2'd2, 1, 1, 1'b0);
      // R3 R4: word write
      run_access("word_wr_hs", 2'd2, 16'h0102, 1'b1, 32'hCAFE_D00D, 4'd3, 4'd4, 1'b1, 1'b0, 2'd0, 3, 0, 1'b0);
      // R9: handshake off, ack forced high and ignored
      run_access("half_rd_nohs", 2'd1, 16'h2001, 1'b0, 32'h0, 4'd2, 4'd3, 1'b0, 1'b1, 2'd0, 1, 0, 1'b1);
      run_access("byte_wr_nohs", 2'd0, 16'h00FF, 1'b1, 32'h0000_005C, 4'd0, 4'd0, 1'b0, 1'b0, 2'd0, 1, 0, 1'b0);
      // R6: maximum counts
      run_access("byte_rd_max", 2'd0, 16'hFFFE, 1'b0, 32'h0, 4'd15, 4'd15, 1'b1, 1'b0, 2'd0, 2, 0, 1'b0);
      // R10: refusals
      run_error("hs_without_sync", 2'd0, 1'b1, 1'b0, 1'b0, 2'd2);
      run_error("reg3_ratio_1to1", 2'd1, 1'b1, 1'b1, 1'b1, 2'd0);
      run_error("reg3_ratio_2to1", 2'd2, 1'b1, 1'b1, 1'b1, 2'd1);
      run_error("size_code_11", 2'd3, 1'b0, 1'b1, 1'b0, 2'd0);
      // after refusals the block still runs normally
      run_access("word_rd_after_err", 2'd2, 16'h5554, 1'b0, 32'h0, 4'd1, 4'd0, 1'b1, 1'b0, 2'd0, 4, 0, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule